// File: doc/BRIEF.md
# Reconfigurable-Region Freeze Controller

This block sits between a register bus and a region of logic that can be reloaded while the rest of the chip keeps running. Software reaches it through a 32-bit register window. Before the region is reloaded, software asks the block to isolate the region. After the reload, software asks it to release the region. The block runs the request/acknowledge handshake with the region for each transition. It holds an isolation output while the region is cut off, and it reports each finished transition as a done flag that stays set.

While the region is isolated, software may ask for a fixed-length reset pulse into the region. A request that the current state does not allow is not carried out. Instead it is recorded in an error register, one bit per request kind. Software clears that register one bit at a time by writing 1 to the bit.

Top module: `pr_freeze_ctrl`

## Requirements
- R1: After reset the block is released. Status reads 2 (bit 1 "released done" set, bit 0 "isolated done" clear). Control and the error register read 0. No request, isolation or reset output is active.
- R2: Register byte offsets are: status at 0, control at 4, error at 8, version at 12. Version reads the parameter VERSION (default 0xAD000003; 2 is also a valid setting). Control reads back the value last written to bits [2:0]. Any other offset reads 0.
- R3: A 0-to-1 change of control bit 0 while released starts isolation. From the next cycle freeze_req_o and freeze_o are high and status reads 0. freeze_req_o stays high until freeze_ack_i is sampled high. In the cycle after that, freeze_req_o is low, status reads 1 and freeze_o stays high.
- R4: A 0-to-1 change of control bit 2 while isolated starts release. From the next cycle unfreeze_req_o is high, status reads 0 and freeze_o stays high. This holds until unfreeze_ack_i is sampled high. In the cycle after that, unfreeze_req_o and freeze_o are low and status reads 2.
- R5: The error register records a disallowed request in the bit that matches its control bit. Bit 0 is set by an isolate request when not released. Bit 1 is set by a reset request when not isolated. Bit 2 is set by a release request when not isolated.
- R6: Error bits accumulate across requests. Writing to offset 8 clears exactly the bits written as 1 and leaves the others unchanged.
- R7: A 0-to-1 change of control bit 1 while isolated drives region_rst_o high for exactly 16 cycles, starting the next cycle. Writing control with bit 1 already set gives no new pulse.
- R8: Writes to the status and version offsets change nothing.
- R9: A disallowed request does not change the state shown in status and does not raise any request or reset output.
- R10: When the acknowledge that ends a transition and a disallowed request fall in the same cycle, both take effect. The transition completes, and the error bit is chosen using the state from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_i | input | 5 | Register byte offset |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data for csr_addr_i (combinational) |
| freeze_req_o | output | 1 | Isolate request to region |
| freeze_ack_i | input | 1 | Isolate acknowledge from region |
| unfreeze_req_o | output | 1 | Release request to region |
| unfreeze_ack_i | input | 1 | Release acknowledge from region |
| freeze_o | output | 1 | Region isolation active |
| region_rst_o | output | 1 | Reset pulse into region |

## Verification
The collision that matters happens when the region's acknowledge that ends a transition lands in the same cycle as a control write whose request the old state forbids. The bench starts an isolation and waits in the requesting phase. On one edge it then raises freeze_ack_i and also writes a release request. After that edge it expects status to show "isolated done", the release-error bit to be set, and no release request to be raised. This shows that the write was judged against the state from before the edge, even though the acknowledge was applied at that same edge.

// File: rtl/pr_freeze_pkg.sv
package pr_freeze_pkg;
  localparam int REG_W     = 32;
  localparam int CTRL_BITS = 3;
  localparam int B_FRZ     = 0;
  localparam int B_RST     = 1;
  localparam int B_UNF     = 2;
  localparam int OFF_STAT  = 0;
  localparam int OFF_CTRL  = 4;
  localparam int OFF_ILL   = 8;
  localparam int OFF_VER   = 12;

  typedef enum logic [1:0] {
    ST_RELEASED  = 2'd0,
    ST_ISOLATING = 2'd1,
    ST_ISOLATED  = 2'd2,
    ST_RELEASING = 2'd3
  } frz_state_e;
endpackage

// File: rtl/pr_freeze_csr.sv
module pr_freeze_csr
  import pr_freeze_pkg::*;
#(
  parameter int          ADDR_W  = 5,
  parameter logic [31:0] VERSION = 32'hAD00_0003
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              st_isolated_i,
  input  logic              st_released_i,
  output logic              frz_go_o,
  output logic              rst_go_o,
  output logic              unf_go_o
);
  logic [CTRL_BITS-1:0] ctrl_q, ill_q, ill_d;
  logic [CTRL_BITS-1:0] allow, rise, go, bad, ill_clr;
  logic                 wr_ctrl, wr_ill;
  logic                 unused_w;

  assign unused_w = ^wdata_i[REG_W-1:CTRL_BITS];
  assign wr_ctrl  = we_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign wr_ill   = we_i && (addr_i == ADDR_W'(OFF_ILL));

  // legality of each request kind in the current state
  assign allow[B_FRZ] = st_released_i;
  assign allow[B_RST] = st_isolated_i;
  assign allow[B_UNF] = st_isolated_i;

  for (genvar b = 0; b < CTRL_BITS; b++) begin : g_bit
    assign rise[b]    = wr_ctrl && wdata_i[b] && !ctrl_q[b];
    assign go[b]      = rise[b] && allow[b];
    assign bad[b]     = rise[b] && !allow[b];
    assign ill_clr[b] = wr_ill && wdata_i[b];
  end

  assign ill_d    = (ill_q & ~ill_clr) | bad;
  assign frz_go_o = go[B_FRZ];
  assign rst_go_o = go[B_RST];
  assign unf_go_o = go[B_UNF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ill_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[CTRL_BITS-1:0];
      ill_q <= ill_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFF_STAT): rdata_o = {{(REG_W-2){1'b0}}, st_released_i, st_isolated_i};
      ADDR_W'(OFF_CTRL): rdata_o = {{(REG_W-CTRL_BITS){1'b0}}, ctrl_q};
      ADDR_W'(OFF_ILL):  rdata_o = {{(REG_W-CTRL_BITS){1'b0}}, ill_q};
      ADDR_W'(OFF_VER):  rdata_o = VERSION;
      default:           rdata_o = '0;
    endcase
  end

  AST_ILL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_ill) |-> ((ill_q & $past(ill_q)) == $past(ill_q))); // R6
  AST_ILL_NO_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ill_q[B_FRZ]) |-> !$past(frz_go_o)); // R9
endmodule

// File: rtl/pr_freeze_fsm.sv
module pr_freeze_fsm
  import pr_freeze_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frz_go_i,
  input  logic unf_go_i,
  input  logic freeze_ack_i,
  input  logic unfreeze_ack_i,
  output logic freeze_req_o,
  output logic unfreeze_req_o,
  output logic freeze_o,
  output logic st_isolated_o,
  output logic st_released_o
);
  frz_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RELEASED:  if (frz_go_i)       state_d = ST_ISOLATING;
      ST_ISOLATING: if (freeze_ack_i)   state_d = ST_ISOLATED;
      ST_ISOLATED:  if (unf_go_i)       state_d = ST_RELEASING;
      ST_RELEASING: if (unfreeze_ack_i) state_d = ST_RELEASED;
      default:                          state_d = ST_RELEASED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RELEASED;
    else         state_q <= state_d;
  end

  assign freeze_req_o   = (state_q == ST_ISOLATING);
  assign unfreeze_req_o = (state_q == ST_RELEASING);
  assign freeze_o       = (state_q != ST_RELEASED);
  assign st_isolated_o  = (state_q == ST_ISOLATED);
  assign st_released_o  = (state_q == ST_RELEASED);

  AST_FRZ_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_req_o && !freeze_ack_i) |=> freeze_req_o); // R3
  AST_ISO_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_isolated_o) |-> $past(freeze_ack_i)); // R3
  AST_REL_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_released_o) |-> $past(unfreeze_ack_i)); // R4
  AST_UNF_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unfreeze_req_o && !unfreeze_ack_i) |=> unfreeze_req_o); // R4
endmodule

// File: rtl/pr_freeze_rst_gen.sv
module pr_freeze_rst_gen #(
  parameter int PULSE_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic rst_o
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (go_i)        cnt_q <= CNT_W'(PULSE_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign rst_o = (cnt_q != '0);

  AST_RST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |-> $past(go_i)); // R7
endmodule

// File: rtl/pr_freeze_ctrl.sv
module pr_freeze_ctrl
  import pr_freeze_pkg::*;
#(
  parameter int          ADDR_W    = 5,
  parameter logic [31:0] VERSION   = 32'hAD00_0003,
  parameter int          PULSE_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_we_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [31:0]       csr_wdata_i,
  output logic [31:0]       csr_rdata_o,
  output logic              freeze_req_o,
  input  logic              freeze_ack_i,
  output logic              unfreeze_req_o,
  input  logic              unfreeze_ack_i,
  output logic              freeze_o,
  output logic              region_rst_o
);
  logic frz_go, rst_go, unf_go, st_isolated, st_released;

  pr_freeze_csr #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_csr (
    .clk_i, .rst_ni,
    .we_i(csr_we_i), .addr_i(csr_addr_i), .wdata_i(csr_wdata_i),
    .rdata_o(csr_rdata_o),
    .st_isolated_i(st_isolated), .st_released_i(st_released),
    .frz_go_o(frz_go), .rst_go_o(rst_go), .unf_go_o(unf_go)
  );

  pr_freeze_fsm u_fsm (
    .clk_i, .rst_ni,
    .frz_go_i(frz_go), .unf_go_i(unf_go),
    .freeze_ack_i, .unfreeze_ack_i,
    .freeze_req_o, .unfreeze_req_o, .freeze_o,
    .st_isolated_o(st_isolated), .st_released_o(st_released)
  );

  pr_freeze_rst_gen #(.PULSE_CYC(PULSE_CYC)) u_rst (
    .clk_i, .rst_ni, .go_i(rst_go), .rst_o(region_rst_o)
  );

  AST_RST_WHILE_ISO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(region_rst_o) |-> $past(st_isolated)); // R7
  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(freeze_req_o && unfreeze_req_o)); // R3
endmodule

// File: tb/sim_pr_freeze_ctrl.sv
module sim_pr_freeze_ctrl;
  localparam logic [4:0] A_STAT = 5'd0, A_CTRL = 5'd4, A_ILL = 5'd8, A_VER = 5'd12;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        frz_req, frz_ack = 1'b0, unf_req, unf_ack = 1'b0, frz, rrst;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  pr_freeze_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .freeze_req_o(frz_req), .freeze_ack_i(frz_ack),
    .unfreeze_req_o(unf_req), .unfreeze_ack_i(unf_ack),
    .freeze_o(frz), .region_rst_o(rrst)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = '0; wdata = '0;
    #1;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_STAT, d); chk("R1", "status", d, 32'd2);
    rd(A_CTRL, d); chk("R1", "ctrl", d, 32'd0);
    rd(A_ILL, d);  chk("R1", "illegal", d, 32'd0);
    chk("R1", "outputs", {frz_req, unf_req, frz, rrst}, 32'd0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    rd(A_VER, d); chk("R2", "version", d, 32'hAD00_0003);
    rd(5'd1, d);  chk("R2", "unaligned offset", d, 32'd0);
    rd(5'd20, d); chk("R2", "unmapped offset", d, 32'd0);
    wr(A_CTRL, 32'hFFFF_FFF0);
    rd(A_CTRL, d); chk("R2", "ctrl readback", d, 32'd0);
  endtask

  task automatic t_ignore;
    logic [31:0] d;
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_VER, 32'h0);
    rd(A_STAT, d); chk("R8", "status after write", d, 32'd2);
    rd(A_VER, d);  chk("R8", "version after write", d, 32'hAD00_0003);
    chk("R8", "outputs", {frz_req, unf_req, frz, rrst}, 32'd0);
  endtask

  task automatic t_illegal_released;
    logic [31:0] d;
    wr(A_CTRL, 0); wr(A_CTRL, 6);
    rd(A_ILL, d);  chk("R5", "reset+release while released", d, 32'd6);
    rd(A_STAT, d); chk("R9", "status unchanged", d, 32'd2);
    chk("R9", "no outputs", {unf_req, rrst, frz}, 32'd0);
    wr(A_ILL, 2);
    rd(A_ILL, d);  chk("R6", "clear bit1 only", d, 32'd4);
    wr(A_CTRL, 0); wr(A_CTRL, 4);
    rd(A_ILL, d);  chk("R6", "bits accumulate", d, 32'd4);
    wr(A_ILL, 4);
    rd(A_ILL, d);  chk("R6", "clear bit2", d, 32'd0);
    wr(A_CTRL, 0);
  endtask

  task automatic t_freeze;
    logic [31:0] d;
    wr(A_CTRL, 1);
    rd(A_STAT, d); chk("R3", "status while isolating", d, 32'd0);
    chk("R3", "req/freeze", {frz_req, frz}, 32'd3);
    repeat (3) @(negedge clk);
    #1 chk("R3", "req held without ack", frz_req, 1'b1);
    frz_ack = 1'b1; @(negedge clk); frz_ack = 1'b0; #1;
    rd(A_STAT, d); chk("R3", "status isolated", d, 32'd1);
    chk("R3", "req dropped, freeze held", {frz_req, frz}, 32'd1);
    wr(A_CTRL, 0);
  endtask

  task automatic t_pulse;
    logic [31:0] d;
    int n;
    wr(A_CTRL, 2);
    n = 0;
    while (rrst && n < 40) begin n++; @(negedge clk); #1; end
    chk("R7", "pulse length", n, 16);
    wr(A_CTRL, 2);
    repeat (3) @(negedge clk);
    #1 chk("R7", "no retrigger on held bit", rrst, 1'b0);
    rd(A_ILL, d); chk("R7", "legal reset no error", d, 32'd0);
    wr(A_CTRL, 0); wr(A_CTRL, 1);
    rd(A_ILL, d);  chk("R5", "isolate while isolated", d, 32'd1);
    rd(A_STAT, d); chk("R9", "status stays isolated", d, 32'd1);
    chk("R9", "no freeze req", frz_req, 1'b0);
    wr(A_ILL, 1); wr(A_CTRL, 0);
  endtask

  task automatic t_unfreeze;
    logic [31:0] d;
    wr(A_CTRL, 4);
    rd(A_STAT, d); chk("R4", "status while releasing", d, 32'd0);
    chk("R4", "req/freeze", {unf_req, frz}, 32'd3);
    unf_ack = 1'b1; @(negedge clk); unf_ack = 1'b0; #1;
    rd(A_STAT, d); chk("R4", "status released", d, 32'd2);
    chk("R4", "req/freeze low", {unf_req, frz}, 32'd0);
    wr(A_CTRL, 0);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    wr(A_CTRL, 1);
    @(negedge clk);
    frz_ack = 1'b1; we = 1'b1; addr = A_CTRL; wdata = 32'd5;
    @(negedge clk);
    frz_ack = 1'b0; we = 1'b0; addr = '0; wdata = '0; #1;
    rd(A_STAT, d); chk("R10", "transition completed", d, 32'd1);
    rd(A_ILL, d);  chk("R10", "release judged on old state", d, 32'd4);
    chk("R10", "no release req", unf_req, 1'b0);
    wr(A_ILL, 7);
    rd(A_ILL, d);  chk("R6", "clear all", d, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    t_reset();
    t_map();
    t_ignore();
    t_illegal_released();
    t_freeze();
    t_pulse();
    t_unfreeze();
    t_collision();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule